// File: doc/BRIEF.md
# Time-Slotted Guaranteed-Throughput Crossbar

This block is a five-port crossbar for traffic that needs a fixed bandwidth and latency. It never arbitrates at run time. Time is cut into slots of three word cycles, and one slot carries exactly one three-word flit on each link. A schedule table with 256 entries says, for each slot and each output, whether that output carries a flit and which input it takes it from. The schedule is built so that no two flows need the same output in the same slot, so no contention can arise.

Each input has a buffer that holds one flit. A flit that arrives in one slot leaves in the next slot, on every output whose table entry for that slot names its input. The global slot index and the word position within the slot are brought out so that neighbouring links can align to the same slot grid. Software or a configuration agent can rewrite single table entries through a one-cycle write port while traffic flows. A new entry is picked up only when its slot begins, so a flit already on an output is never cut off or changed halfway.

Top module: `gt_tdm_switch`

## Requirements
- R1: After reset every output has out_valid low and out_word zero, slot_idx and word_idx are 0, and every table entry is invalid, so no output carries a flit until the table is written.
- R2: word_idx counts 0, 1, 2 and then back to 0, one step per clock. slot_idx goes up by one each time word_idx wraps from 2 to 0, and it wraps from 255 to 0.
- R3: A flit is a run of three words on an input that starts at word_idx 0. It is marked present by in_valid being high at word_idx 0 (in_valid at word_idx 1 and 2 is ignored). Suppose a flit is present on input i in slot n, and the table entry for output o in slot n+1 is valid with source i. Then output o carries word k of that flit when word_idx is k in slot n+1, which is exactly three clocks after the word entered.
- R4: out_valid of an output is set at the start of a slot and keeps the same value for all three word cycles of that slot.
- R5: An output has out_valid low and out_word zero for a slot in any of three cases: its entry for that slot is invalid, its source code is 5, 6 or 7, or the selected input had no flit present in the previous slot.
- R6: Several outputs may name the same input in the same slot. Each of them then carries a full copy of that flit.
- R7: A table entry is a valid bit plus a 3-bit source input number (0 to 4). A write sets the entry picked by tbl_slot and tbl_out. Each output's entry is read on the clock edge that starts its slot, so a write accepted on that edge or later does not change the slot in progress. A write with tbl_out of 5 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 160 | Input words, port p in bits [32p+31:32p] |
| in_valid | input | 5 | Flit present on each input, sampled at word_idx 0 |
| out_word | output | 160 | Output words, port p in bits [32p+31:32p] |
| out_valid | output | 5 | Each output carries a flit in the current slot |
| slot_idx | output | 8 | Current slot number |
| word_idx | output | 2 | Word position inside the current slot |
| tbl_we | input | 1 | Table write strobe |
| tbl_slot | input | 8 | Slot of the entry to write |
| tbl_out | input | 3 | Output of the entry to write |
| tbl_vld | input | 1 | Valid bit written to the entry |
| tbl_src | input | 3 | Source input number written to the entry |

## Verification
slot_idx and word_idx are checked on every clock. Each output word is due exactly three clocks after the input word it copies: the same word position, one slot later. The table entry that decides it is the one held when that slot began, which means writes accepted on or after that edge show up only when the same slot comes round again. The bench model moves forward on each rising edge. At that edge it takes the new slot's entries before it applies any write from the same edge. All outputs are compared with the model at the falling edge, after the design's registers have settled. Directed writes are placed in the middle and in the last word of a slot to test the point at which a new entry takes effect.

// File: rtl/gt_tdm_pkg.sv
package gt_tdm_pkg;
    localparam int SEL_W = 3;

    typedef struct packed {
        logic             vld;
        logic [SEL_W-1:0] src;
    } route_t;
endpackage

// File: rtl/gt_slot_timer.sv
module gt_slot_timer #(
    parameter int FLIT_WORDS = 3,
    parameter int NSLOT      = 256,
    parameter int PH_W       = 2,
    parameter int SLOT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PH_W-1:0]   phase_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [SLOT_W-1:0] next_slot_o,
    output logic              last_o
);
    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [SLOT_W-1:0] slot;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [SLOT_W-1:0] nxt_slot;
    logic              last_word;

    always_comb begin
        st_d      = st_q;
        last_word = (st_q.phase == PH_W'(FLIT_WORDS - 1));
        nxt_slot  = (st_q.slot == SLOT_W'(NSLOT - 1)) ? '0 : st_q.slot + SLOT_W'(1);
        if (last_word) begin
            st_d.phase = '0;
            st_d.slot  = nxt_slot;
        end else begin
            st_d.phase = st_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o     = st_q.phase;
    assign slot_o      = st_q.slot;
    assign next_slot_o = nxt_slot;
    assign last_o      = last_word;
endmodule

// File: rtl/gt_slot_table.sv
module gt_slot_table
    import gt_tdm_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int NSLOT  = 256,
    parameter int SLOT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [SEL_W-1:0]        wr_out,
    input  route_t                  wr_route,
    input  logic                    load,
    input  logic [SLOT_W-1:0]       next_slot,
    output route_t [NPORT-1:0]      row_o
);
    typedef struct packed {
        route_t [NSLOT-1:0][NPORT-1:0] tbl;
        route_t [NPORT-1:0]            row;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the row for the coming slot is taken before any write of this cycle
        if (load) st_d.row = st_q.tbl[next_slot];
        if (wr_en && (int'(wr_out) < NPORT) && (int'(wr_slot) < NSLOT))
            st_d.tbl[wr_slot][wr_out] = wr_route;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_o = st_q.row;
endmodule

// File: rtl/gt_flit_buffer.sv
module gt_flit_buffer #(
    parameter int WORD_W     = 32,
    parameter int FLIT_WORDS = 3,
    parameter int PH_W       = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [PH_W-1:0]                       phase,
    input  logic                                  last,
    input  logic [WORD_W-1:0]                     in_word,
    input  logic                                  in_valid,
    output logic [FLIT_WORDS-1:0][WORD_W-1:0]     words_o,
    output logic                                  present_o
);
    typedef struct packed {
        logic [FLIT_WORDS-1:0][WORD_W-1:0] words;
        logic                              pend;
        logic                              pres;
    } buf_st_t;

    buf_st_t st_d, st_q;
    logic    head;

    always_comb begin
        st_d = st_q;
        head = (phase == '0);
        // word k is overwritten only after it was read out at word k
        if (int'(phase) < FLIT_WORDS) st_d.words[phase] = in_word;
        if (head) st_d.pend = in_valid;
        if (last) st_d.pres = head ? in_valid : st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words_o   = st_q.words;
    assign present_o = st_q.pres;
endmodule

// File: rtl/gt_out_select.sv
module gt_out_select
    import gt_tdm_pkg::*;
#(
    parameter int NPORT      = 5,
    parameter int WORD_W     = 32,
    parameter int FLIT_WORDS = 3,
    parameter int PH_W       = 2
) (
    input  route_t                                        route,
    input  logic [PH_W-1:0]                               phase,
    input  logic [NPORT-1:0][FLIT_WORDS-1:0][WORD_W-1:0]  bufs,
    input  logic [NPORT-1:0]                              pres,
    output logic [WORD_W-1:0]                             word_o,
    output logic                                          valid_o
);
    logic hit;

    always_comb begin
        hit    = 1'b0;
        word_o = '0;
        if (route.vld && (int'(route.src) < NPORT))
            hit = pres[route.src];
        if (hit && (int'(phase) < FLIT_WORDS))
            word_o = bufs[route.src][phase];
    end

    assign valid_o = hit;
endmodule

// File: rtl/gt_tdm_switch.sv
module gt_tdm_switch
    import gt_tdm_pkg::*;
#(
    parameter int  NPORT      = 5,
    parameter int  WORD_W     = 32,
    parameter int  FLIT_WORDS = 3,
    parameter int  NSLOT      = 256,
    localparam int SLOT_W     = $clog2(NSLOT),
    localparam int PH_W       = (FLIT_WORDS > 1) ? $clog2(FLIT_WORDS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT*WORD_W-1:0]   in_word,
    input  logic [NPORT-1:0]          in_valid,
    output logic [NPORT*WORD_W-1:0]   out_word,
    output logic [NPORT-1:0]          out_valid,
    output logic [SLOT_W-1:0]         slot_idx,
    output logic [PH_W-1:0]           word_idx,
    input  logic                      tbl_we,
    input  logic [SLOT_W-1:0]         tbl_slot,
    input  logic [SEL_W-1:0]          tbl_out,
    input  logic                      tbl_vld,
    input  logic [SEL_W-1:0]          tbl_src
);
    logic [PH_W-1:0]                              phase;
    logic [SLOT_W-1:0]                            cur_slot;
    logic [SLOT_W-1:0]                            next_slot;
    logic                                         slot_end;
    route_t [NPORT-1:0]                           row;
    route_t                                       wr_route;
    logic [NPORT-1:0][FLIT_WORDS-1:0][WORD_W-1:0] bufs;
    logic [NPORT-1:0]                             pres;

    gt_slot_timer #(
        .FLIT_WORDS (FLIT_WORDS),
        .NSLOT      (NSLOT),
        .PH_W       (PH_W),
        .SLOT_W     (SLOT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_o     (phase),
        .slot_o      (cur_slot),
        .next_slot_o (next_slot),
        .last_o      (slot_end)
    );

    assign wr_route.vld = tbl_vld;
    assign wr_route.src = tbl_src;

    gt_slot_table #(
        .NPORT  (NPORT),
        .NSLOT  (NSLOT),
        .SLOT_W (SLOT_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_slot   (tbl_slot),
        .wr_out    (tbl_out),
        .wr_route  (wr_route),
        .load      (slot_end),
        .next_slot (next_slot),
        .row_o     (row)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        gt_flit_buffer #(
            .WORD_W     (WORD_W),
            .FLIT_WORDS (FLIT_WORDS),
            .PH_W       (PH_W)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .phase     (phase),
            .last      (slot_end),
            .in_word   (in_word[g*WORD_W +: WORD_W]),
            .in_valid  (in_valid[g]),
            .words_o   (bufs[g]),
            .present_o (pres[g])
        );

        gt_out_select #(
            .NPORT      (NPORT),
            .WORD_W     (WORD_W),
            .FLIT_WORDS (FLIT_WORDS),
            .PH_W       (PH_W)
        ) u_sel (
            .route   (row[g]),
            .phase   (phase),
            .bufs    (bufs),
            .pres    (pres),
            .word_o  (out_word[g*WORD_W +: WORD_W]),
            .valid_o (out_valid[g])
        );
    end

    assign slot_idx = cur_slot;
    assign word_idx = phase;
endmodule

// File: rtl/gt_tdm_switch_chk.sv
module gt_tdm_switch_chk #(
    parameter int  NPORT      = 5,
    parameter int  WORD_W     = 32,
    parameter int  FLIT_WORDS = 3,
    parameter int  NSLOT      = 256,
    localparam int SLOT_W     = $clog2(NSLOT),
    localparam int PH_W       = (FLIT_WORDS > 1) ? $clog2(FLIT_WORDS) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        in_valid,
    input logic [NPORT*WORD_W-1:0] out_word,
    input logic [NPORT-1:0]        out_valid,
    input logic [SLOT_W-1:0]       slot_idx,
    input logic [PH_W-1:0]         word_idx
);
    logic             at_last;
    logic [NPORT-1:0] heads_cur_q;
    logic [NPORT-1:0] heads_prev_q;

    assign at_last = (word_idx == PH_W'(FLIT_WORDS - 1));

    // flits seen in the slot just finished, tracked from the ports only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            heads_cur_q  <= '0;
            heads_prev_q <= '0;
        end else begin
            if (word_idx == '0) heads_cur_q <= in_valid;
            if (at_last) heads_prev_q <= (word_idx == '0) ? in_valid : heads_cur_q;
        end
    end

    assert_word_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(word_idx) < FLIT_WORDS);

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        at_last |=> (slot_idx == (($past(slot_idx) == SLOT_W'(NSLOT - 1)) ? '0
                                  : $past(slot_idx) + SLOT_W'(1))));

    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !at_last |=> $stable(slot_idx));

    assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx != '0) |-> $stable(out_valid));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[p] |-> (out_word[p*WORD_W +: WORD_W] == '0));

        assert_needs_flit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> (heads_prev_q != '0));
    end
endmodule

bind gt_tdm_switch gt_tdm_switch_chk #(
    .NPORT      (NPORT),
    .WORD_W     (WORD_W),
    .FLIT_WORDS (FLIT_WORDS),
    .NSLOT      (NSLOT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_word  (out_word),
    .out_valid (out_valid),
    .slot_idx  (slot_idx),
    .word_idx  (word_idx)
);

// File: tb/tb_gt_tdm_switch.sv
`timescale 1ns/1ps
module tb_gt_tdm_switch;
    localparam int NP = 5;
    localparam int W  = 32;
    localparam int FW = 3;
    localparam int NS = 256;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NP*W-1:0] in_word;
    logic [NP-1:0]   in_valid;
    logic [NP*W-1:0] out_word;
    logic [NP-1:0]   out_valid;
    logic [7:0]      slot_idx;
    logic [1:0]      word_idx;
    logic            tbl_we;
    logic [7:0]      tbl_slot;
    logic [2:0]      tbl_out;
    logic            tbl_vld;
    logic [2:0]      tbl_src;

    always #2 clk = ~clk;

    gt_tdm_switch dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .out_word(out_word), .out_valid(out_valid), .slot_idx(slot_idx),
        .word_idx(word_idx), .tbl_we(tbl_we), .tbl_slot(tbl_slot),
        .tbl_out(tbl_out), .tbl_vld(tbl_vld), .tbl_src(tbl_src)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string tag_ovr  = "";

    // behavioural reference
    bit         m_tv [NS][NP];
    int         m_ts [NS][NP];
    bit         m_rv [NP];
    int         m_rs [NP];
    logic [W-1:0] m_cur  [NP][FW];
    logic [W-1:0] m_prev [NP][FW];
    bit         m_cpend [NP];
    bit         m_ppres [NP];
    int         m_phase, m_slot;
    logic [NP-1:0] prev_ov;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_slot = 0;
            for (int s = 0; s < NS; s++)
                for (int p = 0; p < NP; p++) begin m_tv[s][p] = 0; m_ts[s][p] = 0; end
            for (int p = 0; p < NP; p++) begin
                m_rv[p] = 0; m_rs[p] = 0; m_cpend[p] = 0; m_ppres[p] = 0;
                for (int k = 0; k < FW; k++) begin m_cur[p][k] = '0; m_prev[p][k] = '0; end
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                m_cur[p][m_phase] = in_word[p*W +: W];
                if (m_phase == 0) m_cpend[p] = in_valid[p];
            end
            if (m_phase == FW-1) begin
                m_slot = (m_slot + 1) % NS;
                m_phase = 0;
                for (int p = 0; p < NP; p++) begin
                    m_ppres[p] = m_cpend[p];
                    for (int k = 0; k < FW; k++) m_prev[p][k] = m_cur[p][k];
                    m_rv[p] = m_tv[m_slot][p];
                    m_rs[p] = m_ts[m_slot][p];
                end
            end else begin
                m_phase = m_phase + 1;
            end
            if (tbl_we && tbl_out < NP) begin
                m_tv[tbl_slot][tbl_out] = tbl_vld;
                m_ts[tbl_slot][tbl_out] = int'(tbl_src);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit           ev;
        logic [W-1:0] ew;
        int           src, sharers;
        string        tag;
        check(slot_idx == m_slot[7:0], "R2", "slot_idx", slot_idx, m_slot);
        check(word_idx == m_phase[1:0], "R2", "word_idx", word_idx, m_phase);
        for (int o = 0; o < NP; o++) begin
            src = m_rs[o];
            ev  = m_rv[o] && src < NP && m_ppres[src < NP ? src : 0];
            ew  = ev ? m_prev[src][m_phase] : '0;
            sharers = 0;
            for (int q = 0; q < NP; q++)
                if (m_rv[q] && m_rs[q] == src) sharers++;
            if (tag_ovr.len() > 0) tag = tag_ovr;
            else if (ev && sharers > 1) tag = "R6";
            else if (ev) tag = "R3";
            else tag = "R5";
            check(out_valid[o] == ev, tag, $sformatf("out_valid[%0d]", o), out_valid[o], ev);
            check(out_word[o*W +: W] == ew, tag, $sformatf("out_word[%0d]", o),
                  out_word[o*W +: W], ew);
        end
        if (m_phase != 0)
            check(out_valid == prev_ov, "R4", "out_valid held in slot", out_valid, prev_ov);
        prev_ov = out_valid;
    endtask

    task automatic step(input int wr_pct);
        @(negedge clk);
        compare();
        for (int p = 0; p < NP; p++) in_word[p*W +: W] = $urandom;
        for (int p = 0; p < NP; p++) in_valid[p] = ($urandom % 4) != 0;
        tbl_we = (int'($urandom % 100) < wr_pct);
        tbl_slot = 8'($urandom);
        tbl_out  = 3'($urandom % 8);
        tbl_vld  = ($urandom % 10) != 0;
        tbl_src  = 3'($urandom % 8);
    endtask

    task automatic put(input int s, input int o, input bit v, input int sr);
        tbl_we = 1'b1; tbl_slot = 8'(s); tbl_out = 3'(o); tbl_vld = v; tbl_src = 3'(sr);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("[TB] FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int t;
        rst_n = 1'b0; in_word = '0; in_valid = '0; prev_ov = '0;
        tbl_we = 1'b0; tbl_slot = '0; tbl_out = '0; tbl_vld = 1'b0; tbl_src = '0;
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        check(out_word == '0, "R1", "out_word in reset", out_word[63:0], 0);
        check(slot_idx == '0, "R1", "slot_idx in reset", slot_idx, 0);
        check(word_idx == '0, "R1", "word_idx in reset", word_idx, 0);
        rst_n = 1'b1;

        // R1: empty table, live inputs, nothing leaves
        tag_ovr = "R1";
        repeat (40) step(0);
        tag_ovr = "";

        // random schedules, multicast, reserved codes, slot wrap
        repeat (1500) step(90);
        repeat (600) step(8);

        // R7: writes against the slot in progress
        step(0);
        t = (int'(slot_idx) + 4) % NS;
        put(t, 0, 1'b0, 0);
        step(0);
        put((t + 1) % NS, 1, 1'b0, 0);
        step(0);
        put(t, 6, 1'b1, 2);            // R7: output code 6 ignored
        tag_ovr = "R7";
        while (!(slot_idx == 8'(t) && word_idx == 2'd1)) step(0);
        put(t, 0, 1'b1, 0);            // middle of slot t: not for this slot
        step(0);
        put((t + 1) % NS, 1, 1'b1, 1); // last word of slot t: edge that starts t+1
        for (int i = 0; i < 3; i++) step(0);
        in_valid = '1;
        for (int i = 0; i < 3 * NS + 6; i++) begin
            step(0);
            in_valid = '1;
        end
        tag_ovr = "";

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule